// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block sits behind a clock-recovery stage on an HDLC receive path. It takes the recovered serial bit stream one bit at a time, on each pulse of a bit-enable strobe, and keeps three live status indications in an 8-bit read-only status byte. The first indication is flag reception. The second is line idle. The third is a carrier-sense level that the recovery stage supplies and this block passes through.

Flag detection uses an eight-bit shift window. While no flag is shown, the window is compared against the flag octet 0x7E at every bit. A match sets the flag indication. The indication is then held for a window of eight bit times. A further match anywhere in that window, including one that reuses the closing zero of the previous flag, extends the hold by another eight bits. If no match occurs, the indication drops and the per-bit search resumes. Idle detection counts consecutive ones. The count saturates, and a single zero clears it.

All detection state advances only on strobe cycles. The system clock runs faster than the bit rate. A synchronous active-high reset clears everything.

Top module: `hdlc_line_status`

## Requirements
- R1: Once a clock edge with `rst` high has passed, `statusReg` reads 0x00 whatever the other inputs are. Reset clears the shift window, the flag hold and the idle run count.
- R2: `statusReg[7:3]` always read as zero.
- R3: While the flag indication (`statusReg[2]`) is low, the last eight received bits are compared against 0x7E at every strobe. On the strobe that completes a match, `statusReg[2]` is 1 from the following clock.
- R4: Once set, `statusReg[2]` stays 1 for at least the next eight strobes.
- R5: If a match completes on any of the eight strobes after the flag indication was set or last extended, including the eighth, `statusReg[2]` stays 1 and a new eight-strobe window starts.
- R6: If no match completes within the eight-strobe window, `statusReg[2]` clears after the eighth strobe and the per-bit search resumes.
- R7: The idle indication (`statusReg[0]`) becomes 1 after the fifteenth consecutive received 1.
- R8: A single received 0 clears `statusReg[0]` from the next clock.
- R9: `statusReg[0]` stays 1 for any number of further received 1s, because the run count saturates.
- R10: `statusReg[1]` equals `carrierIn` as it was sampled at the previous clock edge.
- R11: When `bitEn` is low, `rxBit` has no effect, and `statusReg[2]` and `statusReg[0]` do not change.
- R12: A flag that shares its leading zero with the closing zero of the previous flag (seven new bits) counts as a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Bit strobe, one clock per received bit |
| rxBit | input | 1 | Decoded receive bit, valid when `bitEn` is high |
| carrierIn | input | 1 | Carrier sense from the clock-recovery stage |
| statusReg | output | 8 | Status byte: [2] flag, [1] carrier, [0] idle, [7:3] zero |

## Verification
Two events can land on the same strobe: the expiry of a flag hold window and a fresh flag match completing on that window's eighth bit. The bench provokes this by sending two flags back to back with no shared zero, so that the second flag's final zero arrives exactly on the eighth strobe of the hold. The flag bit must stay high with no gap. A second run, in which the window closes without a match, must drop the flag on that same eighth strobe.

// File: rtl/hdlc_ls_pkg.sv
package hdlc_ls_pkg;
  // strobes from datapath to control
  typedef struct packed {
    logic tick;   // a bit is being accepted this cycle
    logic hit;    // window including this bit equals the flag octet
  } lineEv_t;

  typedef enum logic {SEARCH = 1'b0, HOLD = 1'b1} flagState_t;

  // bit positions inside the status byte
  localparam int IDLE_POS  = 0;
  localparam int CARR_POS  = 1;
  localparam int FLAG_POS  = 2;
endpackage

// File: rtl/hdlc_ls_datapath.sv
module hdlc_ls_datapath
  import hdlc_ls_pkg::*;
#(
  parameter int          WIN_BITS = 8,
  parameter logic [WIN_BITS-1:0] FLAG_PAT = 8'h7E,
  parameter int          IDLE_RUN = 15
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    bitEn,
  input  logic    rxBit,
  input  logic    carrierIn,
  output lineEv_t lineEv,
  output logic    idleOn,
  output logic    carrierQ
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_RUN);

  logic [WIN_BITS-1:0] shiftWin;
  logic [WIN_BITS-1:0] nextWin;
  logic [RUN_W-1:0]    runCnt;

  always_comb begin
    nextWin     = {shiftWin[WIN_BITS-2:0], rxBit};
    lineEv.tick = bitEn;
    lineEv.hit  = bitEn && (nextWin == FLAG_PAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftWin <= '0;
    end else if (bitEn) begin
      shiftWin <= nextWin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (bitEn) begin
      if (!rxBit)                runCnt <= '0;
      else if (runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) carrierQ <= 1'b0;
    else     carrierQ <= carrierIn;
  end

  assign idleOn = (runCnt == RUN_MAX);

  p_idle_set_r7: assert property (@(posedge clk) disable iff (rst)
    (bitEn && rxBit && runCnt == RUN_MAX - 1'b1) |=> idleOn);
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bitEn && !rxBit) |=> !idleOn);
  p_idle_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (idleOn && !(bitEn && !rxBit)) |=> idleOn);
endmodule

// File: rtl/hdlc_ls_control.sv
module hdlc_ls_control
  import hdlc_ls_pkg::*;
#(
  parameter int WIN_BITS = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  lineEv_t lineEv,
  output logic    flagOn
);
  localparam int CNT_W = $clog2(WIN_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_BITS - 1);

  flagState_t       state;
  logic [CNT_W-1:0] holdCnt;
  logic             seenFlag;
  logic             windowEnd;

  assign windowEnd = (holdCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEARCH;
      holdCnt  <= '0;
      seenFlag <= 1'b0;
    end else if (lineEv.tick) begin
      case (state)
        SEARCH: begin
          if (lineEv.hit) begin
            state    <= HOLD;
            holdCnt  <= '0;
            seenFlag <= 1'b0;
          end
        end
        HOLD: begin
          if (windowEnd) begin
            holdCnt  <= '0;
            seenFlag <= 1'b0;
            if (!(seenFlag || lineEv.hit)) state <= SEARCH;
          end else begin
            holdCnt  <= holdCnt + 1'b1;
            seenFlag <= seenFlag | lineEv.hit;
          end
        end
        default: state <= SEARCH;
      endcase
    end
  end

  assign flagOn = (state == HOLD);

  p_flag_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (lineEv.tick && lineEv.hit && !flagOn) |=> flagOn);
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (flagOn && !windowEnd) |=> flagOn);
  p_flag_extend_r5: assert property (@(posedge clk) disable iff (rst)
    (flagOn && lineEv.tick && windowEnd && lineEv.hit) |=> (flagOn && holdCnt == '0));
  p_flag_expire_r6: assert property (@(posedge clk) disable iff (rst)
    (flagOn && lineEv.tick && windowEnd && !seenFlag && !lineEv.hit) |=> !flagOn);
endmodule

// File: rtl/hdlc_line_status.sv
module hdlc_line_status
  import hdlc_ls_pkg::*;
#(
  parameter int WIN_BITS = 8,
  parameter logic [WIN_BITS-1:0] FLAG_PAT = 8'h7E,
  parameter int IDLE_RUN = 15,
  parameter int REG_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic             carrierIn,
  output logic [REG_W-1:0] statusReg
);
  localparam int RSV_LO = FLAG_POS + 1;

  lineEv_t lineEv;
  logic    idleOn;
  logic    carrierQ;
  logic    flagOn;

  hdlc_ls_datapath #(
    .WIN_BITS(WIN_BITS), .FLAG_PAT(FLAG_PAT), .IDLE_RUN(IDLE_RUN)
  ) u_datapath (
    .clk(clk), .rst(rst), .bitEn(bitEn), .rxBit(rxBit),
    .carrierIn(carrierIn), .lineEv(lineEv), .idleOn(idleOn),
    .carrierQ(carrierQ)
  );

  hdlc_ls_control #(.WIN_BITS(WIN_BITS)) u_control (
    .clk(clk), .rst(rst), .lineEv(lineEv), .flagOn(flagOn)
  );

  // register packing: live bits, then reserved bits forced low
  assign statusReg[IDLE_POS] = idleOn;
  assign statusReg[CARR_POS] = carrierQ;
  assign statusReg[FLAG_POS] = flagOn;
  for (genvar g = RSV_LO; g < REG_W; g++) begin : g_rsv
    assign statusReg[g] = 1'b0;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (statusReg == '0));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    statusReg[REG_W-1:RSV_LO] == '0);
  p_carrier_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (statusReg[CARR_POS] == $past(carrierIn)));
  p_no_tick_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> ($stable(statusReg[FLAG_POS]) && $stable(statusReg[IDLE_POS])));
endmodule

// File: tb/hdlc_line_status_tb.sv
module hdlc_line_status_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b0;
  logic       carrierIn = 1'b0;
  logic [7:0] statusReg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  hdlc_line_status u_dut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .rxBit(rxBit),
    .carrierIn(carrierIn), .statusReg(statusReg)
  );

  // entry: [7] bit sent, [6] expected flag, [5] expected idle, [3:0] requirement
  localparam int NVEC = 68;
  localparam logic [7:0] VEC [NVEC] = '{
    8'h03, 8'h83, 8'h83, 8'h83, 8'h83, 8'h83, 8'h83, 8'h43,  // R3 first flag
    8'hC4, 8'hC4, 8'hC4, 8'hC4, 8'hC4, 8'hC4, 8'h4C, 8'hC5,  // R12 shared zero, R5 extend
    8'hC4, 8'h44, 8'hC4, 8'h44, 8'hC4, 8'h44, 8'hC4, 8'h06,  // R4 hold, R6 expire
    8'h87, 8'h87, 8'h87, 8'h87, 8'h87, 8'h87, 8'h87, 8'h87,  // R7 ones run
    8'h87, 8'h87, 8'h87, 8'h87, 8'h87, 8'h87, 8'hA7,         // R7 fifteenth one
    8'hA9, 8'hA9, 8'hA9, 8'hA9, 8'hA9,                       // R9 saturation
    8'h08,                                                   // R8 zero clears idle
    8'h83, 8'h83, 8'h83, 8'h83, 8'h83, 8'h83, 8'h43,         // R3 search resumed
    8'h44, 8'hC4, 8'hC4, 8'hC4, 8'hC4, 8'hC4, 8'hC4, 8'h45,  // R5 hit on 8th strobe
    8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 8'h06   // R4 hold, R6 expire
  };

  task automatic check(input logic [7:0] exp, input string req);
    nChecks++;
    if (statusReg !== exp) begin
      nFails++;
      $display("FAIL %s: statusReg=%02h expected %02h", req, statusReg, exp);
    end
  endtask

  // one bit strobe, then a spare clock; returns at a falling edge
  task automatic sendBit(input logic b);
    @(negedge clk); bitEn = 1'b1; rxBit = b;
    @(negedge clk); bitEn = 1'b0; rxBit = ~b;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    // R1: reset with carrier high and strobes active
    carrierIn = 1'b1; bitEn = 1'b1; rxBit = 1'b1;
    repeat (3) @(negedge clk);
    check(8'h00, "R1");
    bitEn = 1'b0; carrierIn = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(8'h00, "R1");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] v;
      v = VEC[i];
      sendBit(v[7]);
      check({5'b0, v[6], 1'b0, v[5]}, $sformatf("R%0d vec%0d", v[3:0], i));
    end

    // R2: reserved bits low while all live bits are set
    doReset();
    carrierIn = 1'b1;
    for (int i = 0; i < 15; i++) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);               // flag set, idle clear
    check(8'h06, "R2");
    nChecks++;
    if (statusReg[7:3] !== 5'b0) begin
      nFails++;
      $display("FAIL R2: reserved=%b expected 00000", statusReg[7:3]);
    end

    // R10: carrier follows with one clock
    @(negedge clk); carrierIn = 1'b0;
    @(negedge clk);
    check(8'h04, "R10");
    carrierIn = 1'b1;
    @(negedge clk);
    check(8'h06, "R10");

    // R1: reset in the middle of a flag hold
    doReset();
    @(negedge clk);
    check(8'h02, "R1");  // carrier back after reset released
    carrierIn = 1'b0;

    // R11: rxBit toggles with no strobe while idle is shown
    for (int i = 0; i < 15; i++) sendBit(1'b1);
    @(negedge clk);
    check(8'h01, "R7");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rxBit = i[0];
    end
    @(negedge clk);
    check(8'h01, "R11");

    // R11: flag held with no strobes
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
    check(8'h04, "R3");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); rxBit = ~rxBit;
    end
    check(8'h04, "R11");
    for (int i = 0; i < 8; i++) sendBit(1'b0);
    check(8'h00, "R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule